// File: doc/BRIEF.md
# Diminished-1 Modulo 2^N+1 Carry-Save Multiplier

This block forms the point-wise product stage of a cyclic convolution built on a number-theoretic transform over the ring of integers modulo 2^N+1. One copy sits at each transform point, and all copies work in parallel. Each copy takes one coefficient from each forward transform and multiplies the two in the ring. The operands arrive in diminished-1 form: an N-bit code holds the value minus one.

The block has no clock, and it never completes the product. It expands the multiplicand into N rotated partial products, one for each multiplier bit. Bits that wrap past the top are inverted on the way round. It then adds three more rows: the two operand codes and a constant correction of one. This gives N+3 rows. A cascade of full-adder rows then reduces them to two N-bit summands. Each level of the cascade compresses the rows down to the next limit of a Dadda height series. Every full adder in the top column sends its carry, inverted, into the bottom column of the next level. The two summands leave the block without being added together. The inverse transform takes them directly, and the sum of the two, modulo 2^N+1, is the diminished-1 code of the product.

Top module: `fnt_modmul_pp`

## Requirements
- R1: For every pair of input codes, (part_s + part_c) mod (2^N+1) equals ((a_dm+1)*(b_dm+1) - 1) mod (2^N+1).
- R2: Every N-bit code is a legal operand. Code 0 stands for the value 1 and the all-ones code stands for the value 2^N. The outputs are fully defined for each code.
- R3: When either operand code is 0, the output residue equals the code of the other operand.
- R4: When b_dm is all ones (the value -1 in the ring), the output residue equals 2^N - 1 - a_dm.
- R5: Swapping the two operands leaves the output residue unchanged.
- R6: When b_dm = 2^j - 1 (the value 2^j), the output residue equals ((a_dm+1)*2^j - 1) mod (2^N+1).
- R7: When 2^N+1 is composite and the ring product is zero, the output residue equals 2^N, which is the code of -1 + 1 - 1 taken modulo 2^N+1.
- R8: The outputs depend only on the present operands. When an earlier pair of codes is applied again, the bench sees the same pair of summands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_dm | input | N | Multiplicand, diminished-1 code |
| b_dm | input | N | Multiplier, diminished-1 code |
| part_s | output | N | First carry-save summand of the product code |
| part_c | output | N | Second carry-save summand of the product code |

## Verification
The bench sweeps every pair of codes for N=8. It also sweeps every pair for N=5, where 2^N+1 is composite, so that ring products of zero occur and the output residue must reach 2^N.

A wrong complement on the wrapped partial-product bits, or on the end-around carry, would move the residue by a fixed offset. That fault shows up at once when one operand is the unit code. A wrong correction constant would shift every result by the same amount, and the unit-code and -1 corners catch it. A tree that dropped a wrapped carry, instead of recirculating it, would give the correct residue only for small products. Operands whose codes are one less than a power of two expose it, because their partial products wrap all the way round.

// File: rtl/fnt_modmul_pkg.sv
package fnt_modmul_pkg;

    // Height limit j of the Dadda series: 2, 3, 4, 6, 9, 13, ...
    function automatic int dadda_cap(input int j);
        int d;
        d = 2;
        for (int s = 0; s < j; s++) d = (d * 3) / 2;
        return d;
    endfunction

    // Number of reduction levels needed to bring k rows down to two
    function automatic int dadda_levels(input int k);
        int lv;
        lv = 0;
        for (int s = 0; s < 32; s++) begin
            if (dadda_cap(lv) < k) lv = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/fnt_modmul_ppgen.sv
module fnt_modmul_ppgen #(
    parameter int N = 8,
    localparam int K = N + 3
) (
    input  logic [N-1:0]   a_dm,
    input  logic [N-1:0]   b_dm,
    output logic [K*N-1:0] rows
);
    // Rows 0..N-1: the multiplicand gated by multiplier bit i, rotated left by i,
    // with the bits that wrap around inverted.
    for (genvar i = 0; i < N; i++) begin : g_rot
        logic [N-1:0] gated;
        assign gated = a_dm & {N{b_dm[i]}};
        if (i == 0) begin : g_plain
            assign rows[i*N +: N] = gated;
        end else begin : g_wrap
            assign rows[i*N +: N] = {gated[N-1-i:0], ~gated[N-1:N-i]};
        end
    end

    // Row N and row N+1 add a_dm + b_dm, which turns a*b into the diminished-1 code.
    assign rows[N*N +: N]     = a_dm;
    assign rows[(N+1)*N +: N] = b_dm;

    // Row N+2: the net correction for all the inverted bits equals one.
    assign rows[(N+2)*N +: N] = {{(N-1){1'b0}}, 1'b1};
endmodule

// File: rtl/fnt_modmul_csa_row.sv
module fnt_modmul_csa_row #(
    parameter int N = 8
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic [N-1:0] z,
    output logic [N-1:0] s,
    output logic [N-1:0] c
);
    logic [N-1:0] maj;

    assign s   = x ^ y ^ z;
    assign maj = (x & y) | (x & z) | (y & z);
    // The carry out of the top column is inverted and enters column zero.
    assign c   = {maj[N-2:0], ~maj[N-1]};
endmodule

// File: rtl/fnt_modmul_tree.sv
module fnt_modmul_tree
    import fnt_modmul_pkg::*;
#(
    parameter int N = 8,
    parameter int K = N + 3,
    localparam int L = dadda_levels(K)
) (
    input  logic [K*N-1:0] rows,
    output logic [N-1:0]   sum0,
    output logic [N-1:0]   sum1
);
    for (genvar l = 0; l < L; l++) begin : g_lvl
        localparam int H = (l == 0) ? K : dadda_cap(L - l);
        localparam int D = dadda_cap(L - 1 - l);
        localparam int F = H - D;

        logic [N-1:0] rin  [K];
        logic [N-1:0] rout [K];

        for (genvar r = 0; r < K; r++) begin : g_in
            if (r >= H) begin : g_idle
                assign rin[r] = '0;
            end else if (l == 0) begin : g_src
                assign rin[r] = rows[r*N +: N];
            end else begin : g_chain
                assign rin[r] = g_lvl[l-1].rout[r];
            end
        end

        for (genvar j = 0; j < F; j++) begin : g_fa
            fnt_modmul_csa_row #(.N(N)) u_row (
                .x (rin[3*j]),
                .y (rin[3*j+1]),
                .z (rin[3*j+2]),
                .s (rout[j]),
                .c (rout[F+j])
            );
        end

        for (genvar r = 2*F; r < K; r++) begin : g_out
            if (r < D) begin : g_pass
                assign rout[r] = rin[r + F];
            end else begin : g_zero
                assign rout[r] = '0;
            end
        end
    end

    assign sum0 = g_lvl[L-1].rout[0];
    assign sum1 = g_lvl[L-1].rout[1];
endmodule

// File: rtl/fnt_modmul_pp.sv
module fnt_modmul_pp #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_dm,
    input  logic [N-1:0] b_dm,
    output logic [N-1:0] part_s,
    output logic [N-1:0] part_c
);
    localparam int K = N + 3;

    logic [K*N-1:0] pp_rows;

    fnt_modmul_ppgen #(.N(N)) u_ppgen (
        .a_dm (a_dm),
        .b_dm (b_dm),
        .rows (pp_rows)
    );

    fnt_modmul_tree #(.N(N), .K(K)) u_tree (
        .rows (pp_rows),
        .sum0 (part_s),
        .sum1 (part_c)
    );
endmodule

// File: rtl/fnt_modmul_pp_chk.sv
module fnt_modmul_pp_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] a_dm,
    input logic [N-1:0] b_dm,
    input logic [N-1:0] part_s,
    input logic [N-1:0] part_c
);
    localparam int W = 2 * N + 4;
    localparam logic [W-1:0] MODV = (W'(1) << N) + W'(1);

    logic [W-1:0] got_res;
    logic [W-1:0] ref_res;

    assign got_res = (W'(part_s) + W'(part_c)) % MODV;
    assign ref_res = ((W'(a_dm) + W'(1)) * (W'(b_dm) + W'(1)) + MODV - W'(1)) % MODV;

    always_comb begin
        if (!$isunknown({a_dm, b_dm})) begin
            AST_KNOWN_SUMMANDS: assert (!$isunknown({part_s, part_c})) else $error("summands unknown"); // R2
            AST_RESIDUE_MATCH: assert (got_res == ref_res) else $error("residue mismatch"); // R1
            if (a_dm == '0) begin
                AST_UNIT_OPERAND: assert (got_res == W'(b_dm)) else $error("unit operand"); // R3
            end
            if (b_dm == '1) begin
                AST_NEG_OPERAND: assert (got_res == (W'(1) << N) - W'(1) - W'(a_dm)) else $error("negation"); // R4
            end
        end
    end
endmodule

bind fnt_modmul_pp fnt_modmul_pp_chk #(.N(N)) u_chk (
    .a_dm   (a_dm),
    .b_dm   (b_dm),
    .part_s (part_s),
    .part_c (part_c)
);

// File: tb/fnt_modmul_pp_bench.sv
module fnt_modmul_pp_bench;
    localparam int NB = 8;
    localparam int NS = 5;
    localparam longint MB = (64'd1 << NB) + 1;
    localparam longint MS = (64'd1 << NS) + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [NB-1:0] a_b, b_b, s_b, c_b;
    logic [NS-1:0] a_s, b_s, s_s, c_s;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    fnt_modmul_pp #(.N(NB)) u_fnt_modmul_pp (
        .a_dm (a_b), .b_dm (b_b), .part_s (s_b), .part_c (c_b)
    );

    fnt_modmul_pp #(.N(NS)) u_small (
        .a_dm (a_s), .b_dm (b_s), .part_s (s_s), .part_c (c_s)
    );

    function automatic longint ref_code(longint a, longint b, longint m);
        return ((a + 1) * (b + 1) + m - 1) % m;
    endfunction

    task automatic check(string tag, longint got, longint exp);
        n_vec++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic apply_b(longint a, longint b);
        @(posedge clk);
        a_b = NB'(a);
        b_b = NB'(b);
        @(negedge clk);
    endtask

    task automatic apply_s(longint a, longint b);
        @(posedge clk);
        a_s = NS'(a);
        b_s = NS'(b);
        @(negedge clk);
    endtask

    function automatic longint res_b();
        return (longint'(s_b) + longint'(c_b)) % MB;
    endfunction

    function automatic longint res_s();
        return (longint'(s_s) + longint'(c_s)) % MS;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        a_b = '0; b_b = '0; a_s = '0; b_s = '0;

        // R2: the extreme codes 0 (value 1) and all ones (value 2^N)
        apply_b(0, 0);
        check("R2 code0*code0", res_b(), 0);
        apply_b(255, 255);
        check("R2 max*max", res_b(), 0);
        apply_b(0, 255);
        check("R2 one*max", res_b(), 255);

        // R3: the unit operand on either side
        for (int v = 0; v < 256; v += 17) begin
            apply_b(0, v);
            check("R3 unit a", res_b(), v);
            apply_b(v, 0);
            check("R3 unit b", res_b(), v);
        end

        // R4: multiplying by -1
        for (int v = 0; v < 256; v += 15) begin
            apply_b(v, 255);
            check("R4 negation", res_b(), 255 - v);
        end

        // R6: powers of two as multiplier
        for (int j = 0; j <= NB; j++) begin
            for (int v = 3; v < 256; v += 61) begin
                apply_b(v, (1 << j) - 1);
                check("R6 power of two", res_b(), ((longint'(v) + 1) * (64'd1 << j) + MB - 1) % MB);
            end
        end

        // R5 and R8: swap the operands, then repeat the first pair
        for (int v = 1; v < 256; v += 37) begin
            longint r0, s0, c0;
            apply_b(v, 255 - v / 2);
            r0 = res_b(); s0 = s_b; c0 = c_b;
            apply_b(255 - v / 2, v);
            check("R5 swap", res_b(), r0);
            apply_b(7, 200);
            apply_b(v, 255 - v / 2);
            check("R8 repeat s", s_b, s0);
            check("R8 repeat c", c_b, c0);
        end

        // R7: composite modulus 33, products that vanish
        apply_s(2, 10);
        check("R7 zero product 3*11", res_s(), 32);
        apply_s(10, 2);
        check("R7 zero product 11*3", res_s(), 32);

        // R1: exhaustive sweep, N=5
        for (int a = 0; a < (1 << NS); a++) begin
            for (int b = 0; b < (1 << NS); b++) begin
                apply_s(a, b);
                check("R1 sweep N=5", res_s(), ref_code(a, b, MS));
            end
        end

        // R1: exhaustive sweep, N=8
        for (int a = 0; a < (1 << NB); a++) begin
            for (int b = 0; b < (1 << NB); b++) begin
                apply_b(a, b);
                check("R1 sweep N=8", res_b(), ref_code(a, b, MB));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule